// File: doc/BRIEF.md
# Cascadable Transposed Multiply-Accumulate Filter Array

This block is the arithmetic core of a configurable FIR engine. It holds three transposed-form sections of seven multiply-accumulate stages each. Each section takes its own 8-bit sample stream and applies every new sample to all seven of its stages in the same cycle. The final partial sum of a section passes through one link register into the first stage of the following section. If the three sample streams are successive taps of one delay line, the array behaves as a single 21-tap filter. If they are three image rows, it behaves as a 3×7 window.

All arithmetic is exact. Data and coefficient operands are widened by one bit so that each can be read as unsigned or as two's complement, on its own, sample by sample. The sum is kept wide enough that 21 products cannot overflow. The coefficient set comes in on a flat bus from storage outside the block, and the block does no post-processing of the sum. The array advances only in cycles that carry a valid sample. `sumOut` and `outValid` are registered, one cycle after the sample is accepted.

Top module: `tfa_array`

## Requirements
- R1: While `rstN` is low, and on the first clock edge after it rises with `inValid` low, `sumOut` reads 0 and `outValid` reads 0. Every internal partial sum also restarts from zero.
- R2: `outValid` is `inValid` delayed by exactly one clock cycle.
- R3: A cycle with `inValid` low changes no state. `sumOut` stays unchanged, and the computation resumes later as if the idle cycles had not occurred.
- R4: Number the accepted samples n = 0, 1, 2, … from reset. After sample n, sumOut = Σ over s∈{0,1,2}, k∈{0..6} of c[s][k]·x_s[n−6+k−8·(2−s)]. Terms with a negative index count as zero.
- R5: Sample x_s occupies `sampleIn[8s+7:8s]`. Coefficient c[s][k] occupies `coefIn[8(7s+k)+7 : 8(7s+k)]`. Stage k=0 is the first stage of a section and k=6 is the last.
- R6: `dataSigned`=1 reads samples as two's complement and 0 reads them as unsigned. `coefSigned` does the same for coefficients. The two flags are independent and are taken per sample.
- R7: `sumOut` is 23 bits two's complement and carries the exact sum with no truncation or rounding. This holds at the extremes: all operands 255 unsigned, all operands −128 signed, and mixed 255 × −128.
- R8: Each product uses the coefficients and format flags present in the cycle its sample is accepted. A coefficient change takes effect mid-stream without a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | The samples on `sampleIn` are accepted this cycle |
| sampleIn | input | 24 | Three 8-bit samples, section s in bits 8s+7:8s |
| coefIn | input | 168 | 21 coefficients of 8 bits, c[s][k] at byte 7s+k |
| dataSigned | input | 1 | 1: samples are two's complement, 0: unsigned |
| coefSigned | input | 1 | 1: coefficients are two's complement, 0: unsigned |
| outValid | output | 1 | `inValid` delayed by one cycle |
| sumOut | output | 23 | Full-precision sum of the last stage of section 2 |

## Verification
The hardest case to reach from the ports is a single output that mixes terms accepted under different coefficient sets and different format flags. The same output also spans idle gaps, because the contributing samples reach back 22 accepted samples across three sections. The bench changes coefficients and both format flags at random on every sample and inserts random idle cycles. It keeps a history of every accepted input and rebuilds each expected sum from the indexing formula. Directed impulses pin down the bit layout, and directed saturating patterns in all format combinations check exactness at the extremes.

// File: rtl/tfa_pkg.sv
package tfa_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic advance;     // accept the sample this cycle
    logic dataSigned;  // sample format for this sample
    logic coefSigned;  // coefficient format for this sample
  } tfaStrobe_t;

  // Exact accumulator width: widened product plus growth for all terms
  function automatic int accWidth(input int dataW, input int coefW, input int terms);
    return dataW + coefW + 2 + $clog2(terms);
  endfunction

endpackage

// File: rtl/tfa_ctrl.sv
module tfa_ctrl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                dataSigned,
  input  logic                coefSigned,
  output tfa_pkg::tfaStrobe_t strobe,
  output logic                outValid
);

  always_comb begin
    strobe.advance    = inValid;
    strobe.dataSigned = dataSigned;
    strobe.coefSigned = coefSigned;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);  // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);  // R2

endmodule

// File: rtl/tfa_mac_stage.sv
module tfa_mac_stage #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 23
) (
  input  logic                clk,
  input  logic                rstN,
  input  tfa_pkg::tfaStrobe_t strobe,
  input  logic [DATA_W-1:0]   sample,
  input  logic [COEF_W-1:0]   coef,
  input  logic [ACC_W-1:0]    prevIn,
  output logic [ACC_W-1:0]    accOut
);

  localparam int PROD_W = DATA_W + COEF_W + 2;

  logic signed [DATA_W:0]   sampleExt;
  logic signed [COEF_W:0]   coefExt;
  logic signed [PROD_W-1:0] product;
  logic [ACC_W-1:0]         productExt;

  always_comb begin
    sampleExt  = $signed({strobe.dataSigned & sample[DATA_W-1], sample});
    coefExt    = $signed({strobe.coefSigned & coef[COEF_W-1], coef});
    product    = sampleExt * coefExt;
    productExt = {{(ACC_W-PROD_W){product[PROD_W-1]}}, product};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               accOut <= '0;
    else if (strobe.advance) accOut <= productExt + prevIn;
  end

  AST_ZERO_TERM: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance && (sample == '0 || coef == '0) |=> accOut == $past(prevIn));  // R4
  AST_UNSIGNED_NONNEG: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance && !strobe.dataSigned && !strobe.coefSigned && !prevIn[ACC_W-1]
      |=> !accOut[ACC_W-1]);  // R7

endmodule

// File: rtl/tfa_datapath.sv
module tfa_datapath #(
  parameter int DATA_W   = 8,
  parameter int COEF_W   = 8,
  parameter int TAPS     = 7,
  parameter int SECTIONS = 3,
  parameter int ACC_W    = 23
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  tfa_pkg::tfaStrobe_t          strobe,
  input  logic [SECTIONS*DATA_W-1:0]   sampleIn,
  input  logic [SECTIONS*TAPS*COEF_W-1:0] coefIn,
  output logic [ACC_W-1:0]             sumOut
);

  logic [ACC_W-1:0] accArr  [SECTIONS][TAPS];
  logic [ACC_W-1:0] prevArr [SECTIONS][TAPS];

  for (genvar s = 0; s < SECTIONS; s++) begin : gSec
    logic [ACC_W-1:0] linkQ;

    if (s == 0) begin : gHead
      assign linkQ = '0;
    end else begin : gLink
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               linkQ <= '0;
        else if (strobe.advance) linkQ <= accArr[s-1][TAPS-1];
      end
    end

    for (genvar k = 0; k < TAPS; k++) begin : gTap
      if (k == 0) begin : gFirst
        assign prevArr[s][k] = linkQ;
      end else begin : gChain
        assign prevArr[s][k] = accArr[s][k-1];
      end

      tfa_mac_stage #(
        .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)
      ) u_stage (
        .clk    (clk),
        .rstN   (rstN),
        .strobe (strobe),
        .sample (sampleIn[s*DATA_W +: DATA_W]),
        .coef   (coefIn[(s*TAPS+k)*COEF_W +: COEF_W]),
        .prevIn (prevArr[s][k]),
        .accOut (accArr[s][k])
      );
    end
  end

  assign sumOut = accArr[SECTIONS-1][TAPS-1];

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> $stable(sumOut));  // R3

endmodule

// File: rtl/tfa_array.sv
module tfa_array #(
  parameter int DATA_W   = 8,
  parameter int COEF_W   = 8,
  parameter int TAPS     = 7,
  parameter int SECTIONS = 3,
  localparam int ACC_W   = tfa_pkg::accWidth(DATA_W, COEF_W, TAPS*SECTIONS),
  localparam int SAMP_W  = SECTIONS*DATA_W,
  localparam int CBUS_W  = SECTIONS*TAPS*COEF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [SAMP_W-1:0] sampleIn,
  input  logic [CBUS_W-1:0] coefIn,
  input  logic              dataSigned,
  input  logic              coefSigned,
  output logic              outValid,
  output logic [ACC_W-1:0]  sumOut
);

  tfa_pkg::tfaStrobe_t strobe;

  tfa_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .dataSigned (dataSigned),
    .coefSigned (coefSigned),
    .strobe     (strobe),
    .outValid   (outValid)
  );

  tfa_datapath #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS),
    .SECTIONS(SECTIONS), .ACC_W(ACC_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sampleIn (sampleIn),
    .coefIn   (coefIn),
    .sumOut   (sumOut)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(sumOut) || $past(inValid));  // R1

endmodule

// File: tb/tfa_array_tb.sv
`timescale 1ns/1ps
module tfa_array_tb;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [23:0]  sampleIn = '0;
  logic [167:0] coefIn = '0;
  logic         dataSigned = 1'b0;
  logic         coefSigned = 1'b0;
  logic         outValid;
  logic [22:0]  sumOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [23:0]  hSamp [64];
  logic [167:0] hCoef [64];
  bit           hDs   [64];
  bit           hCs   [64];
  int accCount = 0;
  int lastExp  = 0;

  always #2.5 clk = ~clk;

  tfa_array u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sampleIn(sampleIn),
    .coefIn(coefIn), .dataSigned(dataSigned), .coefSigned(coefSigned),
    .outValid(outValid), .sumOut(sumOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int opVal(input logic [7:0] v, input bit sgn);
    return sgn ? int'($signed(v)) : int'(v);
  endfunction

  // Expected sum after accepted sample n (R4 indexing formula)
  function automatic int expectAt(input int n);
    int sum = 0;
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < 7; k++) begin
        int idx = n - 6 + k - 8*(2-s);
        if (idx >= 0) begin
          int slot = idx % 64;
          sum += opVal(hSamp[slot][8*s +: 8], hDs[slot]) *
                 opVal(hCoef[slot][8*(7*s+k) +: 8], hCs[slot]);
        end
      end
    end
    return sum;
  endfunction

  // Called at a negedge with inputs already set; returns at the next negedge
  task automatic cycle(input bit v, input string req);
    inValid = v;
    if (v) begin
      hSamp[accCount % 64] = sampleIn;
      hCoef[accCount % 64] = coefIn;
      hDs[accCount % 64]   = dataSigned;
      hCs[accCount % 64]   = coefSigned;
      accCount++;
    end
    @(posedge clk);
    @(negedge clk);
    chk(outValid == v, "R2", int'(outValid), int'(v));
    if (v) lastExp = expectAt(accCount - 1);
    chk(int'($signed(sumOut)) == lastExp, v ? req : "R3",
        int'($signed(sumOut)), lastExp);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    @(negedge clk);
    chk(sumOut == '0, "R1", int'(sumOut), 0);
    chk(outValid == 1'b0, "R1", int'(outValid), 0);
    accCount = 0;
    lastExp = 0;
    rstN = 1'b1;
    @(negedge clk);
    chk(sumOut == '0 && outValid == 1'b0, "R1", int'(sumOut), 0);
  endtask

  function automatic logic [167:0] randCoef();
    logic [167:0] c;
    for (int i = 0; i < 21; i++) c[8*i +: 8] = 8'($urandom);
    return c;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0a11));
    doReset();

    // R5: impulse on each section with distinct per-stage coefficients
    for (int s = 0; s < 3; s++) begin
      for (int i = 0; i < 21; i++) coefIn[8*i +: 8] = 8'(i + 1);
      dataSigned = 1'b0; coefSigned = 1'b0;
      sampleIn = '0;
      sampleIn[8*s +: 8] = 8'd1;
      cycle(1'b1, "R5");
      sampleIn = '0;
      for (int t = 0; t < 24; t++) cycle(1'b1, "R5");
    end

    // R4: random unsigned stream with random idle gaps (R3)
    coefIn = randCoef();
    for (int t = 0; t < 300; t++) begin
      sampleIn = 24'($urandom);
      cycle(($urandom % 4) != 0, "R4");
    end

    // R6: formats change independently per sample
    for (int t = 0; t < 400; t++) begin
      sampleIn   = 24'($urandom);
      dataSigned = 1'($urandom);
      coefSigned = 1'($urandom);
      cycle(($urandom % 5) != 0, "R6");
    end

    // R7: extreme operands in each format combination
    for (int m = 0; m < 3; m++) begin
      for (int t = 0; t < 30; t++) begin
        sampleIn   = (m == 1) ? {3{8'h80}} : {3{8'hFF}};
        coefIn     = (m == 0) ? {21{8'hFF}} : {21{8'h80}};
        dataSigned = (m == 1);
        coefSigned = (m != 0);
        cycle(1'b1, "R7");
      end
    end

    // R1: mid-stream reset clears all partial sums
    doReset();
    sampleIn = '0; coefIn = '0;
    for (int t = 0; t < 24; t++) cycle(1'b1, "R1");

    // R8: coefficients change on every accepted sample
    for (int t = 0; t < 400; t++) begin
      sampleIn   = 24'($urandom);
      coefIn     = randCoef();
      dataSigned = 1'($urandom);
      coefSigned = 1'($urandom);
      cycle(($urandom % 3) != 0, "R8");
    end

    // R3: long idle stretch with inputs wiggling, then resume
    for (int t = 0; t < 20; t++) begin
      sampleIn = 24'($urandom);
      coefIn   = randCoef();
      cycle(1'b0, "R3");
    end
    for (int t = 0; t < 30; t++) begin
      sampleIn = 24'($urandom);
      cycle(1'b1, "R3");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule